// File: doc/BRIEF.md
# Display Identification Presence Probe Sequencer

This block decides whether a monitor is attached to a display connector by checking for the start of its identification data over a two-wire serial bus. The block does not drive the bus wires. It issues whole transactions to an I2C master engine through a small command/response port. Each command carries a target address, a direction, a byte count and one write byte. Each response returns read bytes one per strobe, then a completion strobe with an error flag.

A single-cycle start begins a probe. The block can first write a selector byte to a connector multiplexer, when the caller asks for it. It then writes a zero offset to device address 0x50 and reads eight bytes back from the same address. It counts how many leading bytes match the fixed header 00 FF FF FF FF FF FF 00 and returns a verdict with a done pulse. The verdict is pass only when at least six leading bytes match, because the last two bytes can be repaired later. A NACK or any other bus error on any transaction counts as "no display".

Top module: `ddc_probe_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, and in the cycle after it is released, `busy`, `done`, `pass` and `cmdValid` are all 0. A reset in the middle of a probe returns the block to idle with `pass` cleared.
- R2: With `muxValid` low, the first command after an accepted start is a write (`cmdRead`=0) to address 0x50 with `cmdCount`=1 and `cmdWrData`=0x00.
- R3: When the offset write completes without error, the next command is a read (`cmdRead`=1) from address 0x50 with `cmdCount`=8.
- R4: Read bytes are compared in arrival order against the header 00 FF FF FF FF FF FF 00, where the first received byte is byte 0. The verdict is pass when the number of leading matching bytes is 6 or more, so wrong values in bytes 6 and 7 alone still pass.
- R5: A wrong value in any of bytes 0 to 5 gives a fail verdict.
- R6: If any transaction completes with `rspError`=1, the probe ends with a fail verdict and issues no further command. This holds even if the read returned a correct header.
- R7: With `muxValid` high at start, the first command is a one-byte write of `muxSel` to `muxAddr`. The offset write follows only if that write succeeds, and an error on it ends the probe with fail.
- R8: `done` is a one-cycle pulse in the cycle after the completion strobe of the last transaction. `pass` carries the verdict from that cycle and holds until the next accepted start, which clears it in the following cycle.
- R9: A start asserted while `busy` is high is ignored, and the probe in progress continues unchanged.
- R10: Read bytes beyond the eighth are ignored. A read that completes with fewer than six bytes gives fail.
- R11: `cmdValid` is a single-cycle pulse for each transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe (accepted only when idle) |
| muxValid | input | 1 | Insert the multiplexer select write before the probe |
| muxAddr | input | 7 | Multiplexer device address |
| muxSel | input | 8 | Selector byte written to the multiplexer |
| cmdValid | output | 1 | Command strobe to the bus master |
| cmdAddr | output | 7 | Target device address |
| cmdRead | output | 1 | 1 = read, 0 = write |
| cmdCount | output | 4 | Number of data bytes |
| cmdWrData | output | 8 | Write byte |
| rspByteValid | input | 1 | A read byte is present on rspByte |
| rspByte | input | 8 | Read byte |
| rspDone | input | 1 | Transaction complete |
| rspError | input | 1 | Transaction failed (NACK or error), qualified by rspDone |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished, one-cycle pulse |
| pass | output | 1 | Verdict: display header found |

## Verification
The bound checker checks on every cycle the properties that hold regardless of the data. These are the single-cycle command and done pulses, the address and count of every read command, that a verdict can only rise together with done and only fall after an accepted start, and that busy stays high until done. The ordering of the transactions, the tolerance for bytes 6 and 7, the error paths at each phase, and the handling of short and over-long reads depend on the data returned. Only the bench scenarios can show these, since each one drives a particular response sequence and compares the verdict.

// File: rtl/ddc_probe_pkg.sv
package ddc_probe_pkg;

  typedef enum logic [1:0] {
    K_MUX  = 2'd0,
    K_OFS  = 2'd1,
    K_READ = 2'd2
  } cmd_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      issue;
    cmd_kind_e kind;
    logic      clrScore;
    logic      capture;
    logic      latchVerdict;
    logic      clrPass;
  } dp_ctrl_t;

  // expected header byte: zero at both ends, all ones between
  function automatic logic [7:0] hdrByte(input int unsigned idx, input int unsigned len);
    return (idx == 0 || idx == len - 1) ? 8'h00 : 8'hFF;
  endfunction

endpackage

// File: rtl/ddc_probe_ctrl.sv
module ddc_probe_ctrl
  import ddc_probe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     muxValid,
  input  logic     rspByteValid,
  input  logic     rspDone,
  input  logic     rspError,
  output dp_ctrl_t ctl,
  output logic     busy,
  output logic     done
);

  typedef enum logic [2:0] {
    S_IDLE, S_MUX_CMD, S_MUX_WAIT, S_OFS_CMD, S_OFS_WAIT, S_RD_CMD, S_RD_WAIT, S_FINISH
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    ctl = '0;
    ctl.kind = K_OFS;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          nxt = muxValid ? S_MUX_CMD : S_OFS_CMD;
          ctl.clrPass  = 1'b1;
          ctl.clrScore = 1'b1;
        end
      end
      S_MUX_CMD: begin
        ctl.issue = 1'b1;
        ctl.kind  = K_MUX;
        nxt       = S_MUX_WAIT;
      end
      S_MUX_WAIT: begin
        if (rspDone) nxt = rspError ? S_FINISH : S_OFS_CMD;
      end
      S_OFS_CMD: begin
        ctl.issue = 1'b1;
        ctl.kind  = K_OFS;
        nxt       = S_OFS_WAIT;
      end
      S_OFS_WAIT: begin
        if (rspDone) nxt = rspError ? S_FINISH : S_RD_CMD;
      end
      S_RD_CMD: begin
        ctl.issue = 1'b1;
        ctl.kind  = K_READ;
        nxt       = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        ctl.capture = rspByteValid;
        if (rspDone) begin
          ctl.latchVerdict = !rspError;
          nxt              = S_FINISH;
        end
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);

endmodule

// File: rtl/ddc_probe_dp.sv
module ddc_probe_dp
  import ddc_probe_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         HDR_LEN   = 8,
  parameter int         MIN_MATCH = 6,
  localparam int        IDX_W     = $clog2(HDR_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  dp_ctrl_t         ctl,
  input  logic [6:0]       muxAddr,
  input  logic [7:0]       muxSel,
  input  logic [7:0]       rspByte,
  output logic             cmdValid,
  output logic [6:0]       cmdAddr,
  output logic             cmdRead,
  output logic [IDX_W-1:0] cmdCount,
  output logic [7:0]       cmdWrData,
  output logic             pass
);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] matchCnt;
  logic             run;

  // command field selection
  assign cmdValid  = ctl.issue;
  assign cmdRead   = (ctl.kind == K_READ);
  assign cmdAddr   = (ctl.kind == K_MUX) ? muxAddr : DEV_ADDR;
  assign cmdCount  = (ctl.kind == K_READ) ? IDX_W'(HDR_LEN) : IDX_W'(1);
  assign cmdWrData = (ctl.kind == K_MUX) ? muxSel : 8'h00;

  // leading-match scoring of read bytes
  always_ff @(posedge clk) begin
    if (rst || ctl.clrScore) begin
      idx      <= '0;
      matchCnt <= '0;
      run      <= 1'b1;
    end else if (ctl.capture && (idx < IDX_W'(HDR_LEN))) begin
      idx <= idx + 1'b1;
      if (run && (rspByte == hdrByte(int'(idx), HDR_LEN)))
        matchCnt <= matchCnt + 1'b1;
      else
        run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clrPass) pass <= 1'b0;
    else if (ctl.latchVerdict) pass <= (matchCnt >= IDX_W'(MIN_MATCH));
  end

endmodule

// File: rtl/ddc_probe_seq.sv
module ddc_probe_seq
  import ddc_probe_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         HDR_LEN   = 8,
  parameter int         MIN_MATCH = 6,
  localparam int        IDX_W     = $clog2(HDR_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             muxValid,
  input  logic [6:0]       muxAddr,
  input  logic [7:0]       muxSel,
  output logic             cmdValid,
  output logic [6:0]       cmdAddr,
  output logic             cmdRead,
  output logic [IDX_W-1:0] cmdCount,
  output logic [7:0]       cmdWrData,
  input  logic             rspByteValid,
  input  logic [7:0]       rspByte,
  input  logic             rspDone,
  input  logic             rspError,
  output logic             busy,
  output logic             done,
  output logic             pass
);

  dp_ctrl_t ctl;

  ddc_probe_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .muxValid     (muxValid),
    .rspByteValid (rspByteValid),
    .rspDone      (rspDone),
    .rspError     (rspError),
    .ctl          (ctl),
    .busy         (busy),
    .done         (done)
  );

  ddc_probe_dp #(
    .DEV_ADDR  (DEV_ADDR),
    .HDR_LEN   (HDR_LEN),
    .MIN_MATCH (MIN_MATCH)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .muxAddr   (muxAddr),
    .muxSel    (muxSel),
    .rspByte   (rspByte),
    .cmdValid  (cmdValid),
    .cmdAddr   (cmdAddr),
    .cmdRead   (cmdRead),
    .cmdCount  (cmdCount),
    .cmdWrData (cmdWrData),
    .pass      (pass)
  );

endmodule

// File: rtl/ddc_probe_seq_chk.sv
module ddc_probe_seq_chk #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         HDR_LEN  = 8,
  localparam int        IDX_W    = $clog2(HDR_LEN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cmdValid,
  input logic [6:0]       cmdAddr,
  input logic             cmdRead,
  input logic [IDX_W-1:0] cmdCount,
  input logic             busy,
  input logic             done,
  input logic             pass
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !pass && !done && !cmdValid));

  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst) cmdValid |=> !cmdValid);

  // R3
  read_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdRead) |-> (cmdAddr == DEV_ADDR && cmdCount == IDX_W'(HDR_LEN)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  pass_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(pass) |-> done);

  // R8
  pass_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pass) |-> ($past(start) && !$past(busy)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> busy);

  // R6
  cmd_busy_chk: assert property (@(posedge clk) disable iff (rst) cmdValid |-> (busy && !done));

endmodule

bind ddc_probe_seq ddc_probe_seq_chk #(
  .DEV_ADDR (DEV_ADDR),
  .HDR_LEN  (HDR_LEN)
) chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .cmdValid (cmdValid),
  .cmdAddr  (cmdAddr),
  .cmdRead  (cmdRead),
  .cmdCount (cmdCount),
  .busy     (busy),
  .done     (done),
  .pass     (pass)
);

// File: tb/ddc_probe_seq_test.sv
module ddc_probe_seq_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       muxValid = 1'b0;
  logic [6:0] muxAddr = 7'h70;
  logic [7:0] muxSel = 8'hA5;
  logic       cmdValid;
  logic [6:0] cmdAddr;
  logic       cmdRead;
  logic [3:0] cmdCount;
  logic [7:0] cmdWrData;
  logic       rspByteValid = 1'b0;
  logic [7:0] rspByte = 8'h00;
  logic       rspDone = 1'b0;
  logic       rspError = 1'b0;
  logic       busy, done, pass;

  ddc_probe_seq uut (
    .clk(clk), .rst(rst), .start(start), .muxValid(muxValid), .muxAddr(muxAddr),
    .muxSel(muxSel), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdRead(cmdRead),
    .cmdCount(cmdCount), .cmdWrData(cmdWrData), .rspByteValid(rspByteValid),
    .rspByte(rspByte), .rspDone(rspDone), .rspError(rspError), .busy(busy),
    .done(done), .pass(pass)
  );

  int checks = 0;
  int fails  = 0;

  localparam logic [63:0] GOOD = 64'h00FFFFFFFFFFFF00;

  // {muxValid, errStage(0 none,1 mux,2 offset,3 read), header(byte0 in top), expPass}
  localparam logic [67:0] VECS [11] = '{
    {1'b0, 2'd0, GOOD,                  1'b1},
    {1'b0, 2'd0, 64'h00FFFFFFFFFFFF12,  1'b1},
    {1'b0, 2'd0, 64'h00FFFFFFFFFF3412,  1'b1},
    {1'b0, 2'd0, 64'h00FFFFFFFF00FF00,  1'b0},
    {1'b0, 2'd0, 64'h01FFFFFFFFFFFF00,  1'b0},
    {1'b1, 2'd0, GOOD,                  1'b1},
    {1'b1, 2'd1, GOOD,                  1'b0},
    {1'b0, 2'd2, GOOD,                  1'b0},
    {1'b0, 2'd3, GOOD,                  1'b0},
    {1'b1, 2'd3, GOOD,                  1'b0},
    {1'b0, 2'd0, 64'h00FFFFFFFFFFFFFF,  1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    start = 1'b0; rspDone = 1'b0; rspError = 1'b0; rspByteValid = 1'b0;
  endtask

  task automatic waitCmd(input string req);
    bit got = 1'b0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      clearIn();
      got = cmdValid;
    end
    check(got, req, "command strobe seen", 64'(got), 64'd1);
  endtask

  // bytes then completion; caller's next negedge clears rspDone
  task automatic respond(input bit err, input int nBytes, input logic [63:0] hdr);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      rspByteValid = 1'b1;
      rspByte = (i < 8) ? hdr[63-8*i -: 8] : 8'h5A;
    end
    @(negedge clk);
    rspByteValid = 1'b0;
    rspDone  = 1'b1;
    rspError = err;
  endtask

  task automatic checkEnd(input logic expPass, input string req);
    @(negedge clk);
    clearIn();
    check(done === 1'b1, "R8", "done pulse", 64'(done), 64'd1);
    check(pass === expPass, req, "verdict", 64'(pass), 64'(expPass));
    check(cmdValid === 1'b0, "R6", "no command at done", 64'(cmdValid), 64'd0);
    @(negedge clk);
    check(done === 1'b0 && pass === expPass, "R8", "done drops, verdict held",
          64'({done, pass}), 64'({1'b0, expPass}));
  endtask

  task automatic runProbe(input bit mux, input logic [1:0] errStage, input logic [63:0] hdr,
                          input int nBytes, input logic expPass, input string req);
    @(negedge clk);
    start = 1'b1;
    muxValid = mux;
    if (mux) begin
      waitCmd("R7");
      check(cmdAddr == 7'h70 && !cmdRead && cmdCount == 4'd1 && cmdWrData == 8'hA5, "R7",
            "mux write fields", 64'({cmdAddr, cmdRead, cmdCount, cmdWrData}),
            64'({7'h70, 1'b0, 4'd1, 8'hA5}));
      respond(errStage == 2'd1, 0, hdr);
      if (errStage == 2'd1) begin checkEnd(expPass, req); return; end
    end
    waitCmd("R2");
    check(cmdAddr == 7'h50 && !cmdRead && cmdCount == 4'd1 && cmdWrData == 8'h00, "R2",
          "offset write fields", 64'({cmdAddr, cmdRead, cmdCount, cmdWrData}),
          64'({7'h50, 1'b0, 4'd1, 8'h00}));
    respond(errStage == 2'd2, 0, hdr);
    if (errStage == 2'd2) begin checkEnd(expPass, req); return; end
    waitCmd("R3");
    check(cmdAddr == 7'h50 && cmdRead && cmdCount == 4'd8, "R3", "read fields",
          64'({cmdAddr, cmdRead, cmdCount}), 64'({7'h50, 1'b1, 4'd8}));
    respond(errStage == 2'd3, nBytes, hdr);
    checkEnd(expPass, req);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !pass && !cmdValid, "R1", "idle after reset",
          64'({busy, done, pass, cmdValid}), 64'd0);

    // vector table
    for (int v = 0; v < 11; v++) begin
      string req;
      if (VECS[v][66:65] != 2'd0) req = "R6";
      else if (VECS[v][67])      req = "R7";
      else if (VECS[v][0])       req = "R4";
      else                       req = "R5";
      runProbe(VECS[v][67], VECS[v][66:65], VECS[v][64:1], 8, VECS[v][0], req);
    end

    // R10 extra bytes after the eighth are ignored
    runProbe(1'b0, 2'd0, GOOD, 10, 1'b1, "R10");
    // R10 short read of five good bytes fails
    runProbe(1'b0, 2'd0, GOOD, 5, 1'b0, "R10");
    // R10 exactly six good bytes passes
    runProbe(1'b0, 2'd0, GOOD, 6, 1'b1, "R10");

    // R9 start while busy is ignored
    @(negedge clk);
    start = 1'b1; muxValid = 1'b0;
    waitCmd("R9");
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9", "still busy", 64'(busy), 64'd1);
    rspDone = 1'b1;
    waitCmd("R9");
    check(cmdRead === 1'b1, "R9", "read follows, no restart", 64'(cmdRead), 64'd1);
    respond(1'b0, 8, GOOD);
    checkEnd(1'b1, "R9");

    // R8 verdict held, then cleared by the next start
    repeat (5) @(negedge clk);
    check(pass === 1'b1, "R8", "verdict held while idle", 64'(pass), 64'd1);
    start = 1'b1;
    @(negedge clk);
    clearIn();
    check(pass === 1'b0 && busy === 1'b1, "R8", "verdict cleared on start",
          64'({pass, busy}), 64'({1'b0, 1'b1}));

    // R1 reset mid-probe
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !pass && !cmdValid, "R1", "idle after mid-probe reset",
          64'({busy, done, pass, cmdValid}), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule